// File: doc/BRIEF.md
# Two-Channel PWM Timer with Complementary Dead-Time Stage

This block produces two pulse-width-modulated outputs from the system clock. One shared prescaler slows the clock for both channels. Each channel then has its own divider, chosen by a 3-bit code, and a 16-bit down-counter. The counter reloads from a period register and is compared against a duty register. Each channel has a comparator inversion, a final output inversion and an output enable. Each channel also raises a period event flag and a duty event flag, and each flag has an interrupt enable.

A dead-time stage can be switched on for the pair. Channel 1 then drives the complement of channel 0, and every rising edge on either output is held back by a programmed number of clock cycles. Software reaches all settings through a simple write/read port. The event flags are cleared by writing ones to them.

Top module: `dual_pwm_dz`

## Requirements
- R1: The channel tick interval in clock cycles is (P+1)*D. P is the prescale field, bits [7:0] of address 1, shared by both channels. D comes from the channel's 3-bit divider code at address 2 (channel 0 in bits [2:0], channel 1 in bits [6:4]): code 100 gives 1, 000 gives 2, 001 gives 4, 010 gives 8, 011 gives 16, and any other code gives 1. The output repeats every (PERIOD+1)*(P+1)*D cycles.
- R2: While running, the counter steps down by one on each tick. On the tick after it holds 0 it reloads PERIOD. The comparator level is high while the counter is above CMP, so it is high for PERIOD-CMP of every PERIOD+1 ticks.
- R3: When CMP is greater than or equal to PERIOD, the level stays high for the whole period. When CMP is 0, it stays low for the whole period.
- R4: Control bit 2 (channel 0) or bit 3 (channel 1) at address 0 inverts the comparator level before the dead-time stage.
- R5: Control bit 4 or bit 5 inverts the final output. Output-enable bit 7 or bit 8 being clear holds the output at 0.
- R6: With control bit 6 set, output 1 becomes the complement of output 0. Each output's rising edge is delayed by the dead time, bits [15:8] of address 1, counted in clock cycles. The two outputs are never high together.
- R7: The period flag of a channel (address 7, bit 0 or bit 1) sets when its counter steps down to 0. The duty flag (bit 2 or bit 3) sets when its counter steps onto CMP. A flag clears only when a 1 is written to its bit at address 7.
- R8: irq is high exactly when some set flag has its enable bit set at address 8, where the enable bits use the same positions as the flags.
- R9: PERIOD (addresses 3 and 5) and CMP (addresses 4 and 6) written during a period take effect at the next reload. The period in progress keeps its length.
- R10: With the run bit clear (control bit 0 or bit 1), the counter is held at 0 and the comparator level is low. The counters read back at addresses 9 and 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read data, combinational from addr |
| pwmOut | output | 2 | PWM outputs, channel 0 in bit 0 |
| irq | output | 1 | Interrupt request |

## Verification
A register write is visible on a read at the next falling edge, and a flag appears one cycle after the counter step that caused it. irq follows flags and enables without delay. Each output trails the counter by one register stage, and a rising edge is further held back by the dead-time count when that stage is enabled. Instead of checking single cycles against this fixed latency, the bench counts high cycles over whole periods and measures periods from rising edge to rising edge. Flag and enable checks are taken after the counters are stopped, so nothing is still in flight when they are read.

// File: rtl/dual_pwm_dz_pkg.sv
package dual_pwm_dz_pkg;
  localparam int NCH = 2;

  localparam int A_CTRL = 0;
  localparam int A_TIME = 1;
  localparam int A_DIV  = 2;
  localparam int A_PER0 = 3;
  localparam int A_CMP0 = 4;
  localparam int A_FLAG = 7;
  localparam int A_IEN  = 8;
  localparam int A_CNT0 = 9;

  typedef struct packed {
    logic [NCH-1:0] tick;
    logic [NCH-1:0] run;
  } pwmStrobes_t;
endpackage

// File: rtl/dual_pwm_dz_ctrl.sv
module dual_pwm_dz_ctrl
  import dual_pwm_dz_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 8,
  parameter int DT_W   = 8,
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [CNT_W-1:0]            wrData,
  output logic [CNT_W-1:0]            rdData,
  input  logic [NCH-1:0]              periodHit,
  input  logic [NCH-1:0]              dutyHit,
  input  logic [NCH-1:0][CNT_W-1:0]   cntVec,
  output pwmStrobes_t                 strobes,
  output logic [NCH-1:0][CNT_W-1:0]   perVec,
  output logic [NCH-1:0][CNT_W-1:0]   cmpVec,
  output logic [NCH-1:0]              cmpInv,
  output logic [NCH-1:0]              outInv,
  output logic [NCH-1:0]              oe,
  output logic                        dzEn,
  output logic [DT_W-1:0]             deadTime,
  output logic [2*NCH-1:0]            flagVec,
  output logic [2*NCH-1:0]            ienVec
);
  localparam int CTRL_W = 9;

  logic [CTRL_W-1:0]     ctrlReg;
  logic [PS_W-1:0]       psReg;
  logic [PS_W-1:0]       psCnt;
  logic                  psTick;
  logic [NCH-1:0][2:0]   divSel;
  logic [NCH-1:0]        tickVec;
  logic                  flagClr;

  assign strobes.run  = ctrlReg[1:0];
  assign strobes.tick = tickVec;
  assign cmpInv       = ctrlReg[3:2];
  assign outInv       = ctrlReg[5:4];
  assign dzEn         = ctrlReg[6];
  assign oe           = ctrlReg[8:7];

  // register writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      psReg    <= '0;
      deadTime <= '0;
      divSel   <= '0;
      perVec   <= '0;
      cmpVec   <= '0;
      ienVec   <= '0;
    end else if (wrEn) begin
      case (addr)
        ADDR_W'(A_CTRL): ctrlReg <= wrData[CTRL_W-1:0];
        ADDR_W'(A_TIME): {deadTime, psReg} <= wrData[PS_W+DT_W-1:0];
        ADDR_W'(A_DIV): begin
          for (int c = 0; c < NCH; c++) divSel[c] <= wrData[4*c +: 3];
        end
        ADDR_W'(A_IEN): ienVec <= wrData[2*NCH-1:0];
        default: ;
      endcase
      for (int c = 0; c < NCH; c++) begin
        if (addr == ADDR_W'(A_PER0 + 2*c)) perVec[c] <= wrData;
        if (addr == ADDR_W'(A_CMP0 + 2*c)) cmpVec[c] <= wrData;
      end
    end
  end

  // event flags, set beats clear
  assign flagClr = wrEn && (addr == ADDR_W'(A_FLAG));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagVec <= '0;
    else flagVec <= (flagVec & ~(flagClr ? wrData[2*NCH-1:0] : '0)) | {dutyHit, periodHit};
  end

  // shared prescaler
  assign psTick = (psCnt >= psReg);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) psCnt <= '0;
    else psCnt <= psTick ? '0 : psCnt + 1'b1;
  end

  // per-channel dividers
  for (genvar c = 0; c < NCH; c++) begin : g_div
    logic [3:0] divCnt;
    logic [4:0] divN;
    logic       divLast;
    always_comb begin
      case (divSel[c])
        3'b000:  divN = 5'd2;
        3'b001:  divN = 5'd4;
        3'b010:  divN = 5'd8;
        3'b011:  divN = 5'd16;
        default: divN = 5'd1;
      endcase
    end
    assign divLast    = ({1'b0, divCnt} >= (divN - 5'd1));
    assign tickVec[c] = strobes.run[c] && psTick && divLast;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) divCnt <= '0;
      else if (!strobes.run[c]) divCnt <= '0;
      else if (psTick) divCnt <= divLast ? '0 : divCnt + 1'b1;
    end
  end

  // read mux
  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(A_CTRL):     rdData = CNT_W'(ctrlReg);
      ADDR_W'(A_TIME):     rdData = CNT_W'({deadTime, psReg});
      ADDR_W'(A_DIV):      rdData = CNT_W'({1'b0, divSel[1], 1'b0, divSel[0]});
      ADDR_W'(A_PER0):     rdData = perVec[0];
      ADDR_W'(A_CMP0):     rdData = cmpVec[0];
      ADDR_W'(A_PER0 + 2): rdData = perVec[1];
      ADDR_W'(A_CMP0 + 2): rdData = cmpVec[1];
      ADDR_W'(A_FLAG):     rdData = CNT_W'(flagVec);
      ADDR_W'(A_IEN):      rdData = CNT_W'(ienVec);
      ADDR_W'(A_CNT0):     rdData = cntVec[0];
      ADDR_W'(A_CNT0 + 1): rdData = cntVec[1];
      default:             rdData = '0;
    endcase
  end
endmodule

// File: rtl/dual_pwm_dz_dp.sv
module dual_pwm_dz_dp
  import dual_pwm_dz_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  pwmStrobes_t                 strobes,
  input  logic [NCH-1:0][CNT_W-1:0]   perVec,
  input  logic [NCH-1:0][CNT_W-1:0]   cmpVec,
  input  logic [NCH-1:0]              cmpInv,
  input  logic                        dzEn,
  input  logic [DT_W-1:0]             deadTime,
  output logic [NCH-1:0][CNT_W-1:0]   cntVec,
  output logic [NCH-1:0]              periodHit,
  output logic [NCH-1:0]              dutyHit,
  output logic [NCH-1:0]              dzLvl
);
  logic [NCH-1:0] cmpLvl;
  logic [NCH-1:0] target;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] perAct;
    logic [CNT_W-1:0] cmpAct;
    logic             rawLvl;

    // down-counter; period and compare latched at reload
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt    <= '0;
        perAct <= '0;
        cmpAct <= '0;
      end else if (!strobes.run[c]) begin
        cnt    <= '0;
        perAct <= '0;
        cmpAct <= '0;
      end else if (strobes.tick[c]) begin
        if (cnt == '0) begin
          cnt    <= perVec[c];
          perAct <= perVec[c];
          cmpAct <= cmpVec[c];
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end

    assign rawLvl       = (cmpAct != '0) && ((cnt > cmpAct) || (cmpAct >= perAct));
    assign cmpLvl[c]    = rawLvl ^ cmpInv[c];
    assign periodHit[c] = strobes.tick[c] && (cnt == CNT_W'(1));
    assign dutyHit[c]   = strobes.tick[c] && (cnt != '0) && (cnt == cmpAct + CNT_W'(1));
    assign cntVec[c]    = cnt;
  end

  assign target[0] = cmpLvl[0];
  assign target[1] = dzEn ? ~cmpLvl[0] : cmpLvl[1];

  // dead-time stage: falls pass after one register, rises wait deadTime more
  for (genvar c = 0; c < NCH; c++) begin : g_dz
    logic [DT_W-1:0] dCnt;
    logic            dzQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dzQ  <= 1'b0;
        dCnt <= '0;
      end else if (!target[c]) begin
        dzQ  <= 1'b0;
        dCnt <= '0;
      end else if (dzQ) begin
        dCnt <= '0;
      end else if (!dzEn || dCnt == deadTime) begin
        dzQ  <= 1'b1;
        dCnt <= '0;
      end else begin
        dCnt <= dCnt + 1'b1;
      end
    end
    assign dzLvl[c] = dzQ;
  end
endmodule

// File: rtl/dual_pwm_dz.sv
module dual_pwm_dz
  import dual_pwm_dz_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 8,
  parameter int DT_W   = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic [NCH-1:0]    pwmOut,
  output logic              irq
);
  pwmStrobes_t                strobes;
  logic [NCH-1:0][CNT_W-1:0]  perVec;
  logic [NCH-1:0][CNT_W-1:0]  cmpVec;
  logic [NCH-1:0][CNT_W-1:0]  cntVec;
  logic [NCH-1:0]             cmpInv;
  logic [NCH-1:0]             outInv;
  logic [NCH-1:0]             oe;
  logic                       dzEn;
  logic [DT_W-1:0]            deadTime;
  logic [2*NCH-1:0]           flagVec;
  logic [2*NCH-1:0]           ienVec;
  logic [NCH-1:0]             periodHit;
  logic [NCH-1:0]             dutyHit;
  logic [NCH-1:0]             dzLvl;
  logic [NCH-1:0]             tickVec;

  assign tickVec = strobes.tick;

  dual_pwm_dz_ctrl #(.CNT_W(CNT_W), .PS_W(PS_W), .DT_W(DT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .periodHit(periodHit), .dutyHit(dutyHit), .cntVec(cntVec), .strobes(strobes),
    .perVec(perVec), .cmpVec(cmpVec), .cmpInv(cmpInv), .outInv(outInv), .oe(oe),
    .dzEn(dzEn), .deadTime(deadTime), .flagVec(flagVec), .ienVec(ienVec)
  );

  dual_pwm_dz_dp #(.CNT_W(CNT_W), .DT_W(DT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .perVec(perVec), .cmpVec(cmpVec),
    .cmpInv(cmpInv), .dzEn(dzEn), .deadTime(deadTime), .cntVec(cntVec),
    .periodHit(periodHit), .dutyHit(dutyHit), .dzLvl(dzLvl)
  );

  assign pwmOut = oe & (dzLvl ^ outInv);
  assign irq    = |(flagVec & ienVec);
endmodule

// File: rtl/dual_pwm_dz_chk.sv
module dual_pwm_dz_chk
  import dual_pwm_dz_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [NCH-1:0]    tick,
  input logic [CNT_W-1:0]  cnt0,
  input logic [CNT_W-1:0]  per0,
  input logic              dzEn,
  input logic [NCH-1:0]    dzLvl,
  input logic [2*NCH-1:0]  flags,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [2*NCH-1:0]  wrLow
);
  logic [2*NCH-1:0] clrMask;
  assign clrMask = (wrEn && addr == ADDR_W'(A_FLAG)) ? wrLow : '0;

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick[0] && cnt0 != '0) |=> (cnt0 == $past(cnt0) - CNT_W'(1)));

  p_reload_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tick[0] && cnt0 == '0) |=> (cnt0 == $past(per0)));

  p_dz_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dzEn && $past(dzEn)) |-> !(dzLvl[0] && dzLvl[1]));

  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(flags) & ~$past(clrMask)) & ~flags) == '0));
endmodule

bind dual_pwm_dz dual_pwm_dz_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tickVec), .cnt0(cntVec[0]), .per0(perVec[0]),
  .dzEn(dzEn), .dzLvl(dzLvl), .flags(flagVec), .wrEn(wrEn), .addr(addr),
  .wrLow(wrData[3:0])
);

// File: tb/dual_pwm_dz_test.sv
`timescale 1ns/1ps
module dual_pwm_dz_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0]  pwmOut;
  logic        irq;

  int nChecks = 0;
  int nErr = 0;

  always #2.5 clk = ~clk;

  dual_pwm_dz uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pwmOut(pwmOut), .irq(irq)
  );

  // period, cmp, control word, expected high cycles per period
  localparam logic [15:0] VEC [8][4] = '{
    '{16'd9,  16'd3,  16'h081, 16'd6},   // R2 plain duty
    '{16'd9,  16'd0,  16'h081, 16'd0},   // R3 cmp zero
    '{16'd9,  16'd9,  16'h081, 16'd10},  // R3 cmp equals period
    '{16'd9,  16'd15, 16'h081, 16'd10},  // R3 cmp above period
    '{16'd4,  16'd1,  16'h085, 16'd2},   // R4 comparator inversion
    '{16'd19, 16'd10, 16'h091, 16'd11},  // R5 output inversion
    '{16'd9,  16'd3,  16'h001, 16'd0},   // R5 output disabled
    '{16'd7,  16'd6,  16'h081, 16'd1}    // R2 narrow pulse
  };

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #0.1;
    d = rdData;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic countHigh(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwmOut[ch]) hi++;
    end
  endtask

  task automatic waitRise(input int ch);
    logic prev;
    prev = pwmOut[ch];
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!prev && pwmOut[ch]) break;
      prev = pwmOut[ch];
    end
  endtask

  task automatic measPeriod(input int ch, output int n);
    logic prev;
    waitRise(ch);
    n = 0;
    prev = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      if (!prev && pwmOut[ch]) break;
      prev = pwmOut[ch];
    end
  endtask

  initial begin
    #1000000;
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int hi, hi1, ovl, n;
    logic prev;

    // reset state (R10)
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);
    chk("R10 reset pwmOut", pwmOut, 0);
    chk("R8 reset irq", irq, 0);
    rd(4'd7, d); chk("R7 reset flags", d, 0);
    rd(4'd9, d); chk("R10 reset counter", d, 0);

    // table walk: R2 R3 R4 R5
    wr(4'd1, 16'h0000);
    wr(4'd2, 16'h0044);
    for (int v = 0; v < 8; v++) begin
      int per;
      per = int'(VEC[v][0]);
      wr(4'd0, 16'h0000);
      wr(4'd3, VEC[v][0]);
      wr(4'd4, VEC[v][1]);
      wr(4'd0, VEC[v][2]);
      waitCycles(2 * (per + 1) + 4);
      countHigh(0, 4 * (per + 1), hi);
      chk($sformatf("R2/R3/R4/R5 vector %0d high count", v), hi, 4 * int'(VEC[v][3]));
    end

    // R1 prescaler and divider codes, per=3
    wr(4'd0, 16'h0000);
    wr(4'd3, 16'd3);
    wr(4'd4, 16'd1);
    wr(4'd0, 16'h0081);
    begin
      int psv [5] = '{0, 0, 0, 2, 1};
      int dcv [5] = '{4, 0, 3, 1, 2};
      int exv [5] = '{4, 8, 64, 48, 64};
      for (int k = 0; k < 5; k++) begin
        wr(4'd1, 16'(psv[k]));
        wr(4'd2, 16'h0040 | 16'(dcv[k]));
        measPeriod(0, n);
        measPeriod(0, n);
        chk($sformatf("R1 period ps=%0d code=%0d", psv[k], dcv[k]), n, exv[k]);
      end
    end

    // R9 period written mid-period applies at next reload
    wr(4'd1, 16'h0000);
    wr(4'd2, 16'h0044);
    wr(4'd0, 16'h0000);
    wr(4'd3, 16'd9);
    wr(4'd4, 16'd3);
    wr(4'd0, 16'h0081);
    waitCycles(12);
    waitRise(0);
    n = 0;
    prev = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      if (n == 2) begin wrEn = 1'b1; addr = 4'd3; wrData = 16'd19; end
      else wrEn = 1'b0;
      if (!prev && pwmOut[0]) break;
      prev = pwmOut[0];
    end
    chk("R9 current period keeps old length", n, 10);
    measPeriod(0, n);
    chk("R9 next period uses new value", n, 20);

    // R7 R8 flags and interrupt
    wr(4'd0, 16'h0000);
    wr(4'd7, 16'h000F);
    wr(4'd8, 16'h0000);
    wr(4'd3, 16'd9);
    wr(4'd4, 16'd3);
    wr(4'd0, 16'h0081);
    waitCycles(30);
    wr(4'd0, 16'h0080);
    rd(4'd7, d); chk("R7 period and duty flags set", d, 5);
    chk("R8 irq low with enables off", irq, 0);
    wr(4'd7, 16'h0000);
    rd(4'd7, d); chk("R7 writing zero clears nothing", d, 5);
    wr(4'd8, 16'h0001);
    chk("R8 irq on enabled period flag", irq, 1);
    wr(4'd7, 16'h0001);
    rd(4'd7, d); chk("R7 W1C clears period flag only", d, 4);
    chk("R8 irq drops after clear", irq, 0);
    wr(4'd8, 16'h0004);
    chk("R8 irq on enabled duty flag", irq, 1);

    // R10 stopped counter and level
    rd(4'd9, d); chk("R10 stopped counter reads 0", d, 0);
    chk("R10 stopped output low", pwmOut[0], 0);

    // R6 dead time 3
    wr(4'd3, 16'd9);
    wr(4'd4, 16'd4);
    wr(4'd1, 16'h0300);
    wr(4'd0, 16'h01C1);
    waitCycles(24);
    hi = 0; hi1 = 0; ovl = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwmOut[0]) hi++;
      if (pwmOut[1]) hi1++;
      if (pwmOut[0] && pwmOut[1]) ovl++;
    end
    chk("R6 ch0 high cycles with dead time", hi, 8);
    chk("R6 ch1 high cycles with dead time", hi1, 8);
    chk("R6 no overlap", ovl, 0);

    // R6 dead time 0: plain complement
    wr(4'd1, 16'h0000);
    waitCycles(12);
    hi = 0; hi1 = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwmOut[0]) hi++;
      if (pwmOut[1] != pwmOut[0]) hi1++;
    end
    chk("R6 ch0 high cycles zero dead time", hi, 20);
    chk("R6 ch1 complements ch0", hi1, 40);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule